// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Port

This block is one general-purpose I/O port of 32 pins behind a small synchronous register bus. Each pin has a direction bit and an output data bit. The two-stage synchronised level of every pad can be read back. Each pin can also raise an interrupt request. The request condition is chosen per pin from four triggers: level low, level high, rising edge or falling edge.

Requests collect in a status register. Software clears that register by writing ones. A mask register then selects which pending bits drive the single combined interrupt output. Software can emulate both-edge detection by flipping a pin between the two level modes after each interrupt.

The bus has no wait states. A write takes effect on the clock edge where `bus_wr` is sampled high. Read data is combinational while `bus_rd` is high.

Top module: `gpio_port`

## Requirements
- R1: Register 0x04 holds the direction bits. A 1 in bit n drives `pin_oe[n]` high, making pin n an output. The register resets to 0, so every pin starts as an input.
- R2: Register 0x00 holds the output data. Bit n appears on `pin_out[n]` from the edge that writes it, and the register reads back as written. It resets to 0.
- R3: Register 0x08 reads the pad levels after a two-flop synchroniser. A change on `pin_in` becomes readable after two clock edges. Writes to 0x08 have no effect.
- R4: The trigger fields are 2 bits per pin. Register 0x0C holds pins 0–15 and register 0x10 holds pins 16–31. Pin n's field sits at bit 2×(n mod 16). The encodings are 00 = level low, 01 = level high, 10 = rising edge and 11 = falling edge. Both registers reset to 0.
- R5: In a level mode, the pin's status bit is set on every cycle in which the synchronised level matches the mode. Clearing the bit does not stick while that level holds.
- R6: In an edge mode, the status bit is set once, in the cycle after the synchronised value changes in the selected direction. It is not set again until the next such transition.
- R7: Register 0x18 is the status register. Writing a 1 to a bit clears it. Writing a 0 leaves the bit unchanged.
- R8: When a trigger sets a status bit on the same edge that a write clears that bit, the bit ends up set.
- R9: Register 0x14 is the mask register, and it resets to 0. `irq` is high exactly when some bit is set in both status and mask.
- R10: Reads of addresses with no register (0x1C and up) return 0. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_rd` is high |
| pin_in | input | 32 | Asynchronous pad levels |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pad |
| irq | output | 1 | Combined masked interrupt request |

## Verification
Two events can land on the same status bit in one clock: a trigger setting it, and a software write clearing it. The bench provokes this with level-mode pins held at their active level while the status register is cleared. It also times a rising edge so that the synchronised edge arrives on exactly the cycle a clear write commits. In both cases the bench expects the bit to read back as 1. A behavioural model advanced on every clock predicts the status, pad outputs and interrupt line, and the bench compares against it on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPINS  = 32;
    localparam int DW     = 32;
    localparam int AW     = 5;
    localparam int HALF   = NPINS / 2;

    localparam logic [AW-1:0] OFF_DATA = 5'h00;
    localparam logic [AW-1:0] OFF_DIR  = 5'h04;
    localparam logic [AW-1:0] OFF_PAD  = 5'h08;
    localparam logic [AW-1:0] OFF_TLO  = 5'h0C;
    localparam logic [AW-1:0] OFF_THI  = 5'h10;
    localparam logic [AW-1:0] OFF_MASK = 5'h14;
    localparam logic [AW-1:0] OFF_STAT = 5'h18;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [DW-1:0] dir;
        logic [DW-1:0] tlo;
        logic [DW-1:0] thi;
        logic [DW-1:0] mask;
        logic [DW-1:0] stat;
    } port_regs_t;

    function automatic logic trig_hit(trig_e mode, logic cur, logic prev);
        logic r;
        case (mode)
            TRIG_LOW:  r = ~cur;
            TRIG_HIGH: r = cur;
            TRIG_RISE: r = cur & ~prev;
            default:   r = ~cur & prev;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_cur,
    output logic [W-1:0] q_prev
);
    logic [STAGES:0][W-1:0] chain;

    assign chain[0] = d_async;

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_prev <= '0;
        else     q_prev <= chain[STAGES];
    end

    assign q_cur = chain[STAGES];
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
    import gpio_pkg::*;
#(
    parameter int PINS = NPINS
) (
    input  logic [PINS-1:0] cur,
    input  logic [PINS-1:0] prev,
    input  logic [DW-1:0]   cfg_lo,
    input  logic [DW-1:0]   cfg_hi,
    output logic [PINS-1:0] hit
);
    localparam int H = PINS / 2;

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        trig_e mode;
        if (g < H) begin : g_lo
            assign mode = trig_e'(cfg_lo[2*g +: 2]);
        end else begin : g_hi
            assign mode = trig_e'(cfg_hi[2*(g-H) +: 2]);
        end
        assign hit[g] = trig_hit(mode, cur[g], prev[g]);
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic [DW-1:0] pad_lvl,
    input  logic [DW-1:0] hit,
    output port_regs_t    regs,
    output logic [DW-1:0] clr,
    output logic [DW-1:0] rdata
);
    port_regs_t nxt;

    function automatic logic wsel(bus_req_t r, logic [AW-1:0] off);
        return r.wr && (r.addr == off);
    endfunction

    always_comb begin
        clr = wsel(req, OFF_STAT) ? req.wdata : '0;
        nxt = regs;
        if (wsel(req, OFF_DATA)) nxt.data = req.wdata;
        if (wsel(req, OFF_DIR))  nxt.dir  = req.wdata;
        if (wsel(req, OFF_TLO))  nxt.tlo  = req.wdata;
        if (wsel(req, OFF_THI))  nxt.thi  = req.wdata;
        if (wsel(req, OFF_MASK)) nxt.mask = req.wdata;
        nxt.stat = (regs.stat & ~clr) | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) regs <= '0;
        else     regs <= nxt;
    end

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            case (req.addr)
                OFF_DATA: rdata = regs.data;
                OFF_DIR:  rdata = regs.dir;
                OFF_PAD:  rdata = pad_lvl;
                OFF_TLO:  rdata = regs.tlo;
                OFF_THI:  rdata = regs.thi;
                OFF_MASK: rdata = regs.mask;
                OFF_STAT: rdata = regs.stat;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [4:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [31:0]   pin_in,
    output logic [31:0]   pin_out,
    output logic [31:0]   pin_oe,
    output logic          irq
);
    bus_req_t      req;
    port_regs_t    regs;
    logic [DW-1:0] cur_w, prev_w, hit_w, clr_w;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(pin_in), .q_cur(cur_w), .q_prev(prev_w)
    );

    gpio_trig #(.PINS(NPINS)) u_trig (
        .cur(cur_w), .prev(prev_w), .cfg_lo(regs.tlo), .cfg_hi(regs.thi), .hit(hit_w)
    );

    gpio_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .pad_lvl(cur_w), .hit(hit_w),
        .regs(regs), .clr(clr_w), .rdata(bus_rdata)
    );

    assign pin_out = regs.data;
    assign pin_oe  = regs.dir;
    assign irq     = |(regs.stat & regs.mask);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic [31:0] pin_out,
    input logic [31:0] stat_q,
    input logic [31:0] mask_q,
    input logic [31:0] hit_q,
    input logic [31:0] clr_q,
    input logic        irq
);
    AST_STAT_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (($past(stat_q) & ~stat_q & ~$past(clr_q)) == 32'h0)); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (|hit_q) |=> (($past(hit_q) & ~stat_q) == 32'h0)); // R8

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 32'h0) |-> !irq); // R9

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 5'h00) |=> $stable(pin_out)); // R2

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 32'h0)); // R10
endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .stat_q(regs.stat), .mask_q(regs.mask),
    .hit_q(hit_w), .clr_q(clr_w), .irq(irq)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, pin_in = '0;
    logic [31:0] bus_rdata, pin_out, pin_oe;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_port u0 (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

    // behavioural reference
    logic [31:0] m_data, m_dir, m_tlo, m_thi, m_mask, m_stat, m_s1, m_s2, m_p;

    function automatic logic [31:0] m_hits();
        logic [31:0] h = '0;
        for (int n = 0; n < 32; n++) begin
            int md = (n < 16) ? int'(m_tlo[2*n +: 2]) : int'(m_thi[2*(n-16) +: 2]);
            case (md)
                0: h[n] = !m_s2[n];
                1: h[n] = m_s2[n];
                2: h[n] = m_s2[n] && !m_p[n];
                default: h[n] = !m_s2[n] && m_p[n];
            endcase
        end
        return h;
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a)
            5'h00: return m_data;
            5'h04: return m_dir;
            5'h08: return m_s2;
            5'h0C: return m_tlo;
            5'h10: return m_thi;
            5'h14: return m_mask;
            5'h18: return m_stat;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            {m_data, m_dir, m_tlo, m_thi, m_mask, m_stat, m_s1, m_s2, m_p} = '0;
        end else begin
            logic [31:0] h, c;
            h = m_hits();
            c = (bus_wr && bus_addr == 5'h18) ? bus_wdata : 32'h0;
            m_stat = (m_stat & ~c) | h;
            m_p = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            if (bus_wr) begin
                case (bus_addr)
                    5'h00: m_data = bus_wdata;
                    5'h04: m_dir  = bus_wdata;
                    5'h0C: m_tlo  = bus_wdata;
                    5'h10: m_thi  = bus_wdata;
                    5'h14: m_mask = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 pin_out", pin_out, m_data);
            chk("R1 pin_oe", pin_oe, m_dir);
            chk("R9 irq", {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [4:0] a, string tag, output logic [31:0] v);
        bus_rd = 1; bus_addr = a;
        #1 v = bus_rdata;
        chk(tag, v, m_read(a));
        bus_rd = 0;
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst = 0;
        idle(2);
        // reset state
        rd(5'h00, "R2 reset data", v);  chk("R2 reset literal", v, 32'h0);
        rd(5'h04, "R1 reset dir", v);   chk("R1 reset literal", v, 32'h0);
        rd(5'h0C, "R4 reset tlo", v);   chk("R4 reset literal", v, 32'h0);
        rd(5'h14, "R9 reset mask", v);  chk("R9 reset literal", v, 32'h0);
        rd(5'h18, "R5 low-level fill", v); chk("R5 all low pins pend", v, 32'hFFFF_FFFF);
        chk("R9 masked irq", {31'h0, irq}, 32'h0);
        // data / direction
        wr(5'h00, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_0000);
        chk("R2 pin_out literal", pin_out, 32'hA5A5_0F0F);
        chk("R1 pin_oe literal", pin_oe, 32'hFFFF_0000);
        // pad readback
        pin_in = 32'h8000_0004;
        idle(3);
        rd(5'h08, "R3 pad", v); chk("R3 pad literal", v, 32'h8000_0004);
        wr(5'h08, 32'h0);
        rd(5'h08, "R3 write ignored", v); chk("R3 write ignored literal", v, 32'h8000_0004);
        // triggers: p0 rise, p1 fall, p2 high, p17 high, p31 fall
        wr(5'h0C, 32'h0000_001E);
        wr(5'h10, 32'hC000_0004);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, "R8 level re-set", v); chk("R4 R8 status literal", v, 32'h7FFD_FFFC);
        // rising edge on pin 0
        pin_in[0] = 1'b1;
        idle(4);
        rd(5'h18, "R6 rise", v); chk("R6 rise literal", v[0], 1'b1);
        wr(5'h18, 32'h1);
        idle(3);
        rd(5'h18, "R7 clear", v); chk("R7 clear literal", v[0], 1'b0);
        wr(5'h18, 32'h0);
        rd(5'h18, "R7 zero write", v); chk("R7 zero keeps pin2", v[2], 1'b1);
        // fall on pin 1 (rise first must not set)
        pin_in[1] = 1'b1; idle(4);
        rd(5'h18, "R6 no fall", v); chk("R6 rise ignored on fall pin", v[1], 1'b0);
        pin_in[1] = 1'b0; idle(4);
        rd(5'h18, "R6 fall", v); chk("R6 fall literal", v[1], 1'b1);
        // mask
        wr(5'h14, 32'h0002_0000);
        chk("R9 unmatched mask", {31'h0, irq}, 32'h0);
        wr(5'h14, 32'h0000_0002);
        chk("R9 matched mask", {31'h0, irq}, 32'h1);
        wr(5'h18, 32'h0000_0002);
        chk("R9 cleared", {31'h0, irq}, 32'h0);
        // same-edge set vs clear on pin 0
        pin_in[0] = 1'b0; idle(4);
        wr(5'h18, 32'h1);
        pin_in[0] = 1'b1;
        idle(2);
        wr(5'h18, 32'h1);
        rd(5'h18, "R8 edge collide", v); chk("R8 collide literal", v[0], 1'b1);
        // pin 17 high level in upper register
        pin_in[17] = 1'b1; idle(4);
        rd(5'h18, "R4 upper field", v); chk("R4 pin17 literal", v[17], 1'b1);
        // unmapped / idle read
        rd(5'h1C, "R10 unmapped", v); chk("R10 unmapped literal", v, 32'h0);
        chk("R10 idle rdata", bus_rdata, 32'h0);
        idle(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule